// File: doc/BRIEF.md
# Clocked Serial Transceiver

This block moves bytes between a parallel host side and a pair of serial lines. Each direction has one shift register and one holding register. The bit clock runs at the bit rate itself, with one clock period per bit and no oversampling. Transmit data changes on the rising edge of the bit clock. Receive data is sampled on its falling edge. The bit clock comes from one of two sources:

- an internal rate timer, whose clock level is driven out on a bidirectional clock pin;
- an external clock arriving on that same pin.

Each frame is one low start bit, the data bits sent least significant bit first, and one high stop bit. The host writes a byte into the transmit holding register. The block moves that byte into the shift register on its own, and a new byte written in time follows the previous frame with no gap. On the receive side, each completed frame is copied to a holding register. Three status flags report problems: overrun, frame error and receive busy. All three are active low. The host clears the overrun and frame-error flags with a one-cycle strobe.

In asynchronous receive mode, the receive rate timer stays stopped while the line is idle. Each start-bit edge restarts it, so a sender running slightly off the programmed rate is still received correctly.

Top module: `sio_xcvr`

## Requirements
- R1: A transmitted frame on `sout` is a 0 start bit, then `tx_byte` bits 0 to 7 in that order, then a 1 stop bit. Each bit lasts one bit-clock period. With the internal timer, one period is 2*(`rate_div`+1) clock cycles.
- R2: `sout` changes only on a rising edge of the transmit bit clock. With the internal timer, `bclk_out` rises at the start of each bit and falls (`rate_div`+1) cycles later, in the middle of the bit.
- R3: In synchronous receive (`use_ext_clk`=1, `async_rx`=0), `sin` is sampled on each falling edge of `bclk_in`. A sampled 0 while idle starts a frame, and the data bits are taken least significant bit first.
- R4: A byte waiting in the transmit holding register moves into the shift register at the bit-clock edge that ends the current stop bit, or at the next rising edge if the line is idle. That move raises `tx_need_p` for one cycle. Two frames sent this way are exactly 10 bit periods apart.
- R5: `tx_idle` is a live level. It is 1 exactly while the transmit shift register holds no frame.
- R6: When the stop bit has been sampled, the received byte appears on `rx_byte`, `rx_ready_p` pulses for one cycle, and `rx_pending` goes to 1. `rx_pending` stays at 1 until `rx_ack` is pulsed.
- R7: `rx_ovr_n` goes to 0 if a frame completes while `rx_pending` is still 1.
- R8: `rx_ferr_n` goes to 0 when the stop bit is sampled as 0. Pulsing `stat_clr` sets both `rx_ovr_n` and `rx_ferr_n` back to 1.
- R9: While `force_break` is 1, `sout` is held at 0.
- R10: When `async_rx` is 1, the internal receive timer is stopped while idle and restarts on every falling edge of `sin`. Its first sample lands mid-bit, so frames sent up to 5% slower than the programmed rate are still received.
- R11: `sin_level` reports the level of `sin` after the input synchronizer (two cycles of delay by default), whether or not the shift register is in use.
- R12: `rx_busy_n` is 0 from start-bit detection until the stop bit has been sampled, and is 1 otherwise.
- R13: With `use_ext_clk`=0, `bclk_oe` is 1 and the internal transmit timer drives `bclk_out`. With `use_ext_clk`=1, `bclk_oe` is 0 and the transmitter is clocked from `bclk_in`.
- R14: After reset: `sout`=1, `tx_idle`=1, `rx_pending`=0, and `rx_busy_n`, `rx_ovr_n` and `rx_ferr_n` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_div | input | DIV_W | Half-period reload of the internal rate timers |
| use_ext_clk | input | 1 | Select the external bit clock on the clock pin |
| async_rx | input | 1 | Asynchronous receive with start-bit resynchronisation |
| bclk_in | input | 1 | Clock pin, input side |
| bclk_out | output | 1 | Clock pin, output side |
| bclk_oe | output | 1 | Clock pin output enable |
| sin | input | 1 | Serial data input |
| sout | output | 1 | Serial data output |
| force_break | input | 1 | Hold `sout` low |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_byte | input | DATA_W | Byte to transmit |
| rx_byte | output | DATA_W | Receive holding register |
| rx_ack | input | 1 | Clears `rx_pending` |
| stat_clr | input | 1 | Sets the overrun and frame-error flags back to 1 |
| tx_need_p | output | 1 | Pulse: holding register moved into the shift register |
| tx_idle | output | 1 | Transmit shift register empty |
| rx_ready_p | output | 1 | Pulse: a received byte was stored |
| rx_pending | output | 1 | Received byte not yet acknowledged |
| sin_level | output | 1 | Synchronized raw `sin` level |
| rx_busy_n | output | 1 | Active low: frame being received |
| rx_ovr_n | output | 1 | Active low: overrun |
| rx_ferr_n | output | 1 | Active low: frame error |

## Verification
The bench writes the second byte only after the first one has moved into the shift register, so the no-gap handoff is exercised. A design that left the stop bit too short or added an idle bit would move the two start edges away from exactly ten bit periods apart. A design that sampled on the wrong clock edge, or sent the most significant bit first, would corrupt the byte patterns in the scoreboard. Two asynchronous frames are sent 5% slower than the programmed rate: without start-bit resynchronisation the stop bit is sampled in the wrong place, which corrupts data and flags false frame errors. Overrun and a stop bit of 0 are provoked on purpose, and the bench checks that the status strobe clears them, so flags that stick, clear themselves or invert would be caught.

// File: rtl/sio_pkg.sv
package sio_pkg;

    // Start and stop bits added around every data word.
    localparam int SIO_FRAME_EXTRA = 2;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/sio_bit_timer.sv
// Rate timer: square-wave bit clock, level flips every (div_i+1) cycles.
// tick_o announces that lvl_o flips at the coming edge.
module sio_bit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             lvl_o,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } tmr_state_t;

    tmr_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (restart_i || !run_i) begin
            nxt_d.cnt = div_i;
            nxt_d.lvl = 1'b1;
        end else if (cur_q.cnt == '0) begin
            nxt_d.cnt = div_i;
            nxt_d.lvl = ~cur_q.lvl;
        end else begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q     <= '0;
            cur_q.lvl <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign lvl_o  = cur_q.lvl;
    assign tick_o = run_i && !restart_i && (cur_q.cnt == '0);

    // R13: an announced toggle really flips the clock level
    a_r13_tick_flips: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (lvl_o != $past(lvl_o)));

endmodule

// File: rtl/sio_edge_sync.sv
// Synchronizer for a pin: level after STAGES flops, tick_o when it is about to change.
module sio_edge_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic tick_o
);

    logic [STAGES-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign lvl_o  = sh_q[STAGES-1];
    assign tick_o = sh_q[STAGES-2] ^ sh_q[STAGES-1];

    // R11: the synchronized level follows the stage ahead of it
    a_r11_follow: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (lvl_o != $past(lvl_o)));

endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              force_i,
    output logic              sout_o,
    output logic              idle_o,
    output logic              need_o
);

    localparam int FRAME_W = DATA_W + SIO_FRAME_EXTRA;
    localparam int CNT_W   = $clog2(FRAME_W);

    typedef struct packed {
        logic [DATA_W-1:0]  hold;
        logic               hold_full;
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   left;
        logic               active;
        logic               line;
        logic               need;
    } tx_state_t;

    tx_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.need = 1'b0;
        if (rise_i) begin
            if (cur_q.active && (cur_q.left != '0)) begin
                nxt_d.shreg = {1'b1, cur_q.shreg[FRAME_W-1:1]};
                nxt_d.line  = cur_q.shreg[1];
                nxt_d.left  = cur_q.left - 1'b1;
            end else if (cur_q.hold_full) begin
                nxt_d.shreg     = {1'b1, cur_q.hold, 1'b0};
                nxt_d.line      = 1'b0;
                nxt_d.left      = CNT_W'(FRAME_W - 1);
                nxt_d.active    = 1'b1;
                nxt_d.hold_full = 1'b0;
                nxt_d.need      = 1'b1;
            end else begin
                nxt_d.active = 1'b0;
                nxt_d.line   = 1'b1;
            end
        end
        if (wr_i) begin
            nxt_d.hold      = data_i;
            nxt_d.hold_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            cur_q.line <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sout_o = force_i ? 1'b0 : cur_q.line;
    assign idle_o = !cur_q.active;
    assign need_o = cur_q.need;

    // R2: the line only moves at a rising bit-clock edge
    a_r2_line_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q.line) |-> $past(rise_i));
    // R4: a handoff happens only at a rising edge
    a_r4_need_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        need_o |-> $past(rise_i));
    // R5: after a handoff the shift register is busy
    a_r5_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        need_o |-> !idle_o);
    // R9: break holds the output low
    a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i && $past(force_i)) |-> !sout_o);

endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic              bit_i,
    input  logic              start_i,
    input  logic              async_i,
    input  logic              ack_i,
    input  logic              clr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o,
    output logic              pending_o,
    output logic              active_o,
    output logic              busy_n_o,
    output logic              ovr_n_o,
    output logic              ferr_n_o
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        rx_state_e         st;
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] hold;
        logic              pending;
        logic              ready;
        logic              ovr_n;
        logic              ferr_n;
    } rx_state_t;

    rx_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.ready = 1'b0;
        if (ack_i) nxt_d.pending = 1'b0;
        if (clr_i) begin
            nxt_d.ovr_n  = 1'b1;
            nxt_d.ferr_n = 1'b1;
        end
        unique case (cur_q.st)
            RX_IDLE: begin
                if (async_i) begin
                    if (start_i) nxt_d.st = RX_START;
                end else if (strobe_i && !bit_i) begin
                    nxt_d.st  = RX_DATA;
                    nxt_d.cnt = '0;
                end
            end
            RX_START: begin
                if (strobe_i) begin
                    nxt_d.st  = bit_i ? RX_IDLE : RX_DATA;
                    nxt_d.cnt = '0;
                end
            end
            RX_DATA: begin
                if (strobe_i) begin
                    nxt_d.shreg = {bit_i, cur_q.shreg[DATA_W-1:1]};
                    if (cur_q.cnt == CNT_W'(DATA_W - 1)) nxt_d.st = RX_STOP;
                    else                                  nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            RX_STOP: begin
                if (strobe_i) begin
                    nxt_d.st      = RX_IDLE;
                    nxt_d.hold    = cur_q.shreg;
                    nxt_d.ready   = 1'b1;
                    nxt_d.pending = 1'b1;
                    if (!bit_i)        nxt_d.ferr_n = 1'b0;
                    if (cur_q.pending) nxt_d.ovr_n  = 1'b0;
                end
            end
            default: nxt_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q        <= '0;
            cur_q.st     <= RX_IDLE;
            cur_q.ovr_n  <= 1'b1;
            cur_q.ferr_n <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign data_o    = cur_q.hold;
    assign ready_o   = cur_q.ready;
    assign pending_o = cur_q.pending;
    assign active_o  = (cur_q.st != RX_IDLE);
    assign busy_n_o  = (cur_q.st == RX_IDLE);
    assign ovr_n_o   = cur_q.ovr_n;
    assign ferr_n_o  = cur_q.ferr_n;

    // R6: a stored byte is always pending
    a_r6_ready_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> pending_o);
    // R7: completion over a pending byte flags overrun
    a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && $past(pending_o)) |-> !ovr_n_o);
    // R8: status strobe restores the flags when no frame completes
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_i) && !ready_o) |-> (ovr_n_o && ferr_n_o));
    // R12: busy ends with the stop-bit sample
    a_r12_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> busy_n_o);

endmodule

// File: rtl/sio_xcvr.sv
module sio_xcvr #(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  rate_div,
    input  logic              use_ext_clk,
    input  logic              async_rx,
    input  logic              bclk_in,
    output logic              bclk_out,
    output logic              bclk_oe,
    input  logic              sin,
    output logic              sout,
    input  logic              force_break,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] rx_byte,
    input  logic              rx_ack,
    input  logic              stat_clr,
    output logic              tx_need_p,
    output logic              tx_idle,
    output logic              rx_ready_p,
    output logic              rx_pending,
    output logic              sin_level,
    output logic              rx_busy_n,
    output logic              rx_ovr_n,
    output logic              rx_ferr_n
);

    logic ext_lvl, ext_tick;
    logic sin_tick;
    logic txt_lvl, txt_tick;
    logic rxt_lvl, rxt_tick;
    logic rx_active;
    logic sin_fall, rx_restart, rx_run;
    logic tx_rise, rx_strobe;

    sio_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_clk_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(bclk_in), .lvl_o(ext_lvl), .tick_o(ext_tick)
    );

    sio_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sin_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(sin), .lvl_o(sin_level), .tick_o(sin_tick)
    );

    // Transmit timer runs freely; receive timer may be held and restarted.
    sio_bit_timer #(.DIV_W(DIV_W)) u_tx_timer (
        .clk(clk), .rst_n(rst_n), .run_i(1'b1), .restart_i(1'b0),
        .div_i(rate_div), .lvl_o(txt_lvl), .tick_o(txt_tick)
    );

    assign sin_fall   = sin_tick && sin_level;
    assign rx_restart = async_rx && !rx_active && sin_fall;
    assign rx_run     = !async_rx || rx_active || rx_restart;

    sio_bit_timer #(.DIV_W(DIV_W)) u_rx_timer (
        .clk(clk), .rst_n(rst_n), .run_i(rx_run), .restart_i(rx_restart),
        .div_i(rate_div), .lvl_o(rxt_lvl), .tick_o(rxt_tick)
    );

    assign tx_rise   = use_ext_clk ? (ext_tick && !ext_lvl) : (txt_tick && !txt_lvl);
    assign rx_strobe = (use_ext_clk && !async_rx) ? (ext_tick && ext_lvl)
                                                  : (rxt_tick && rxt_lvl);

    assign bclk_out = use_ext_clk ? ext_lvl : txt_lvl;
    assign bclk_oe  = !use_ext_clk;

    sio_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .rise_i(tx_rise), .wr_i(tx_wr), .data_i(tx_byte),
        .force_i(force_break), .sout_o(sout), .idle_o(tx_idle), .need_o(tx_need_p)
    );

    sio_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .strobe_i(rx_strobe), .bit_i(sin_level),
        .start_i(rx_restart), .async_i(async_rx), .ack_i(rx_ack), .clr_i(stat_clr),
        .data_o(rx_byte), .ready_o(rx_ready_p), .pending_o(rx_pending),
        .active_o(rx_active), .busy_n_o(rx_busy_n), .ovr_n_o(rx_ovr_n),
        .ferr_n_o(rx_ferr_n)
    );

    // R13: the pin is driven only when the internal clock is selected
    a_r13_pin_dir: assert property (@(posedge clk) disable iff (!rst_n)
        use_ext_clk |-> !bclk_oe);
    // R10: while asynchronous and idle, the receive clock is parked high
    a_r10_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (async_rx && $past(async_rx) && !rx_active && $past(!rx_active && !rx_restart))
            |-> rxt_lvl);

endmodule

// File: tb/tb_sio_xcvr.sv
module tb_sio_xcvr;

    localparam int DIV = 9;
    localparam int P   = 2 * (DIV + 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rate_div = 8'(DIV);
    logic       use_ext_clk = 1'b0, async_rx = 1'b1, bclk_in = 1'b0, sin = 1'b1;
    logic       force_break = 1'b0, tx_wr = 1'b0, rx_ack = 1'b0, stat_clr = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       bclk_out, bclk_oe, sout, tx_need_p, tx_idle, rx_ready_p, rx_pending;
    logic       sin_level, rx_busy_n, rx_ovr_n, rx_ferr_n;
    logic [7:0] rx_byte;

    sio_xcvr dut (
        .clk(clk), .rst_n(rst_n), .rate_div(rate_div), .use_ext_clk(use_ext_clk),
        .async_rx(async_rx), .bclk_in(bclk_in), .bclk_out(bclk_out), .bclk_oe(bclk_oe),
        .sin(sin), .sout(sout), .force_break(force_break), .tx_wr(tx_wr),
        .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_ack(rx_ack), .stat_clr(stat_clr),
        .tx_need_p(tx_need_p), .tx_idle(tx_idle), .rx_ready_p(rx_ready_p),
        .rx_pending(rx_pending), .sin_level(sin_level), .rx_busy_n(rx_busy_n),
        .rx_ovr_n(rx_ovr_n), .rx_ferr_n(rx_ferr_n)
    );

    always #4 clk = ~clk;

    int  n_chk = 0, n_fail = 0;
    int  cyc = 0;
    bit  done = 1'b0;
    logic [7:0] tx_exp[$];
    logic [7:0] rx_exp[$];
    int  start_a = 0, start_b = 0;
    bit  mon_en = 1'b0, mon_ext = 1'b0;
    int  need_cnt = 0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (tx_need_p) need_cnt <= need_cnt + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // TX monitor: decodes frames on sout and compares with the scoreboard
    initial begin
        logic prev_s = 1'b1;
        logic b1;
        logic [7:0] got;
        logic [7:0] want;
        forever begin
            @(negedge clk);
            if (mon_en && prev_s && !sout) begin
                start_a = start_b;
                start_b = cyc;
                if (!mon_ext)
                    chk(bclk_out == 1'b1, "R2 clock rises with start bit", bclk_out, 1);
                repeat (P/2 - 1) @(negedge clk);
                b1 = bclk_out;
                @(negedge clk);
                if (!mon_ext)
                    chk(b1 && !bclk_out, "R2 clock falls mid-bit", {b1, bclk_out}, 2'b10);
                chk(sout == 1'b0, "R1 start bit", sout, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (P) @(negedge clk);
                    got[i] = sout;
                end
                repeat (P) @(negedge clk);
                chk(sout == 1'b1, "R1 stop bit", sout, 1);
                if (tx_exp.size() == 0) begin
                    chk(1'b0, "R1 unexpected frame", got, 0);
                end else begin
                    want = tx_exp.pop_front();
                    chk(got == want, "R1 tx byte", got, want);
                end
            end
            prev_s = sout;
        end
    end

    // RX monitor
    initial begin
        logic [7:0] want;
        forever begin
            @(negedge clk);
            if (rx_ready_p) begin
                if (rx_exp.size() == 0) begin
                    chk(1'b0, "R6 unexpected byte", rx_byte, 0);
                end else begin
                    want = rx_exp.pop_front();
                    chk(rx_byte == want, "R6 rx byte", rx_byte, want);
                end
            end
        end
    end

    task automatic send_tx(input logic [7:0] b);
        tx_exp.push_back(b);
        @(negedge clk);
        tx_byte = b;
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic wait_need();
        int n0;
        n0 = need_cnt;
        while (need_cnt == n0) @(negedge clk);
    endtask

    task automatic async_frame(input logic [7:0] b, input logic stop, input int per);
        logic [9:0] f;
        rx_exp.push_back(b);
        f = {stop, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            sin = f[i];
            repeat (per - 1) @(negedge clk);
        end
        @(negedge clk);
        sin = 1'b1;
        repeat (per) @(negedge clk);
    endtask

    task automatic ext_frame(input logic [7:0] b);
        logic [9:0] f;
        rx_exp.push_back(b);
        f = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            bclk_in = 1'b1;
            sin = f[i];
            repeat (P/2) @(negedge clk);
            bclk_in = 1'b0;
            repeat (P/2 - 1) @(negedge clk);
        end
        @(negedge clk);
        sin = 1'b1;
        repeat (P) @(negedge clk);
    endtask

    task automatic ext_clocks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bclk_in = 1'b1;
            repeat (P/2) @(negedge clk);
            bclk_in = 1'b0;
            repeat (P/2 - 1) @(negedge clk);
        end
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    initial begin
        int t0, highs;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        chk(sout == 1'b1, "R14 sout idle", sout, 1);
        chk(tx_idle == 1'b1, "R14 tx_idle", tx_idle, 1);
        chk(rx_pending == 1'b0, "R14 rx_pending", rx_pending, 0);
        chk({rx_busy_n, rx_ovr_n, rx_ferr_n} == 3'b111, "R14 status",
            {rx_busy_n, rx_ovr_n, rx_ferr_n}, 7);
        chk(bclk_oe == 1'b1, "R13 internal clock drives pin", bclk_oe, 1);

        // R13 internal bit clock period
        while (bclk_out != 1'b0) @(negedge clk);
        while (bclk_out != 1'b1) @(negedge clk);
        t0 = cyc;
        highs = 0;
        @(negedge clk);
        while (!(bclk_out == 1'b1 && highs > 0 && cyc - t0 >= P)) begin
            if (bclk_out == 1'b0) highs++;
            @(negedge clk);
        end
        chk(cyc - t0 == P, "R13 clock period", cyc - t0, P);
        chk(highs == P/2, "R13 clock low half", highs, P/2);

        // R1/R4/R5 back-to-back transmit
        mon_en = 1'b1;
        send_tx(8'hA5);
        wait_need();
        chk(need_cnt == 1, "R4 need pulse on first load", need_cnt, 1);
        @(negedge clk);
        chk(tx_idle == 1'b0, "R5 busy while shifting", tx_idle, 0);
        send_tx(8'h3C);
        wait_need();
        chk(need_cnt == 2, "R4 need pulse on handoff", need_cnt, 2);
        repeat (P) @(negedge clk);
        chk(start_b - start_a == 10 * P, "R4 no gap between frames", start_b - start_a, 10 * P);
        while (!tx_idle) @(negedge clk);
        repeat (P) @(negedge clk);
        chk(tx_idle == 1'b1, "R5 idle after last frame", tx_idle, 1);
        send_tx(8'h00);
        wait_need();
        send_tx(8'hFF);
        wait_need();
        while (!tx_idle) @(negedge clk);
        repeat (P) @(negedge clk);
        chk(tx_exp.size() == 0, "R1 all frames seen", tx_exp.size(), 0);

        // R9 forced break
        mon_en = 1'b0;
        @(negedge clk);
        force_break = 1'b1;
        highs = 0;
        for (int i = 0; i < 3 * P; i++) begin
            @(negedge clk);
            if (sout) highs++;
        end
        chk(highs == 0, "R9 break holds sout low", highs, 0);
        force_break = 1'b0;
        repeat (2) @(negedge clk);
        chk(sout == 1'b1, "R9 line returns after break", sout, 1);
        mon_en = 1'b1;

        // R6/R10/R12 asynchronous receive
        fork
            async_frame(8'h96, 1'b1, P);
            begin
                repeat (P) @(negedge clk);
                chk(rx_busy_n == 1'b0, "R12 busy during frame", rx_busy_n, 0);
            end
        join
        chk(rx_busy_n == 1'b1, "R12 not busy after stop", rx_busy_n, 1);
        chk(rx_pending == 1'b1, "R6 pending after frame", rx_pending, 1);
        pulse(rx_ack);
        @(negedge clk);
        chk(rx_pending == 1'b0, "R6 ack clears pending", rx_pending, 0);
        async_frame(8'h5A, 1'b1, P + 1);
        pulse(rx_ack);
        async_frame(8'hC3, 1'b1, P + 1);
        pulse(rx_ack);
        chk(rx_ferr_n == 1'b1, "R10 slow frames keep framing", rx_ferr_n, 1);
        chk(rx_ovr_n == 1'b1, "R7 no overrun when acked", rx_ovr_n, 1);

        // R7 overrun, R8 clear
        async_frame(8'h11, 1'b1, P);
        async_frame(8'h22, 1'b1, P);
        chk(rx_ovr_n == 1'b0, "R7 overrun flagged", rx_ovr_n, 0);
        pulse(stat_clr);
        @(negedge clk);
        chk(rx_ovr_n == 1'b1, "R8 clear restores overrun", rx_ovr_n, 1);
        pulse(rx_ack);

        // R8 frame error
        async_frame(8'h77, 1'b0, P);
        chk(rx_ferr_n == 1'b0, "R8 bad stop bit", rx_ferr_n, 0);
        pulse(stat_clr);
        @(negedge clk);
        chk(rx_ferr_n == 1'b1, "R8 clear restores framing", rx_ferr_n, 1);
        pulse(rx_ack);

        // R11/R13 external clock, synchronous receive
        @(negedge clk);
        use_ext_clk = 1'b1;
        async_rx = 1'b0;
        mon_ext = 1'b1;
        @(negedge clk);
        chk(bclk_oe == 1'b0, "R13 pin released in external mode", bclk_oe, 0);
        sin = 1'b0;
        repeat (3) @(negedge clk);
        chk(sin_level == 1'b0, "R11 raw level low", sin_level, 0);
        chk(rx_busy_n == 1'b1, "R11 raw read leaves receiver idle", rx_busy_n, 1);
        sin = 1'b1;
        repeat (3) @(negedge clk);
        chk(sin_level == 1'b1, "R11 raw level high", sin_level, 1);

        // R3 synchronous receive on the external clock
        ext_frame(8'hC5);
        pulse(rx_ack);
        ext_frame(8'h3A);
        pulse(rx_ack);
        chk(rx_ferr_n && rx_ovr_n, "R3 clean synchronous frames", {rx_ferr_n, rx_ovr_n}, 3);

        // R13 transmitter clocked from the pin
        send_tx(8'h81);
        ext_clocks(13);
        chk(tx_idle == 1'b1, "R13 external clock drives tx", tx_idle, 1);
        repeat (P) @(negedge clk);
        chk(tx_exp.size() == 0, "R13 ext frame decoded", tx_exp.size(), 0);
        chk(rx_exp.size() == 0, "R6 all bytes received", rx_exp.size(), 0);

        done = 1'b1;
    end

    initial begin
        int k;
        k = 0;
        while (!done && k < 200000) begin
            @(posedge clk);
            k++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=done", k);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule